// File: doc/BRIEF.md
# Digital Phase-Select Data Recovery Loop

This block is the digital timing-recovery loop of one serial receive lane. A phase detector outside the block compares incoming data transitions with the sampling clock and reports, each cycle, whether the sample point sits early or late. The loop integrates these decisions in a signed accumulator, which acts as a low-pass filter. Only when the accumulator crosses a threshold does it move a phase-select index by one step. That index picks which of several phases of a shared multiphase oscillator retimes the data. Isolated or alternating decisions cancel out, so input jitter never reaches the phase selector.

The block also drives the receive data word. In normal tracking the retimed word passes through with one register stage. When tracking is switched off the loop freezes and the word stops toggling. In a manufacturing test mode, external increment and decrement pulses steer the accumulator, and its value is shown on the data word. A lock flag rises after a programmable number of consecutive cycles without a phase step.

Top module: `cdr_phase_loop`

## Requirements
- R1: While rst_ni is low, phase_idx_o is 0, locked_o is 0, rx_data_o is 0 and the accumulator is 0.
- R2: While tracking, early_i alone adds 1 to the accumulator. When it reaches +THRESH (8), phase_idx_o advances by one on that clock edge and the accumulator returns to 0.
- R3: While tracking, late_i alone subtracts 1. When the accumulator reaches -THRESH, phase_idx_o retards by one and the accumulator returns to 0.
- R4: Alternating early and late decisions never move phase_idx_o, because the accumulator never reaches either threshold.
- R5: phase_idx_o wraps modulo NUM_PHASES (16). Advancing from NUM_PHASES-1 gives 0, and retarding from 0 gives NUM_PHASES-1. Each change is exactly one step.
- R6: early_i and late_i high together mark invalid data and count as +1. The phase therefore keeps ramping forward by one step every THRESH cycles.
- R7: With track_en_i = 0 and test_mode_i = 0, the accumulator and phase_idx_o hold, rx_data_o keeps its last value, and locked_o is 0.
- R8: With test_mode_i = 1, each cycle with test_inc_i alone adds 1 and each cycle with test_dec_i alone subtracts 1. Both together leave the accumulator unchanged. The accumulator wraps in ACC_W bits, phase_idx_o never moves, and rx_data_o shows the new accumulator value, sign-extended to 10 bits, one edge after the pulse.
- R9: locked_o rises on the edge that completes lock_limit_i consecutive step-free tracking cycles. It drops on the edge that steps the phase or leaves tracking.
- R10: While tracking outside test mode, rx_data_o equals the rx_data_i present before the previous clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Recovered-domain clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| track_en_i | input | 1 | 1 = track incoming data, 0 = hold the loop |
| test_mode_i | input | 1 | Test override: accumulator driven by pulse inputs |
| test_inc_i | input | 1 | Test pulse, accumulator +1 |
| test_dec_i | input | 1 | Test pulse, accumulator -1 |
| early_i | input | 1 | Phase detector: sample early |
| late_i | input | 1 | Phase detector: sample late |
| lock_limit_i | input | 8 | Step-free cycles required for lock |
| rx_data_i | input | 10 | Retimed data word |
| rx_data_o | output | 10 | Data word, or accumulator in test mode |
| phase_idx_o | output | 4 | Selected sampling phase |
| locked_o | output | 1 | Lock indication |

## Verification
Every result is due on the first clock edge after the stimulus cycle. The phase step, the accumulator clear, the lock flag and the output word all register on the same edge that consumes the decision, so the zero-latency case is exactly one edge. The bench drives inputs just after a falling edge, lets one rising edge pass, and samples at the next falling edge. Threshold scenarios check one cycle before the crossing and at the crossing, which catches an off-by-one either way.

// File: rtl/cdr_loop_pkg.sv
package cdr_loop_pkg;
  typedef enum logic [1:0] {
    STEP_NONE = 2'd0,
    STEP_FWD  = 2'd1,
    STEP_BACK = 2'd2
  } step_e;
endpackage

// File: rtl/cdr_loop_filter.sv
module cdr_loop_filter
  import cdr_loop_pkg::*;
#(
  parameter int ACC_W  = 8,
  parameter int THRESH = 8
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    hold_i,
  input  logic                    test_i,
  input  logic                    early_i,
  input  logic                    late_i,
  input  logic                    test_inc_i,
  input  logic                    test_dec_i,
  output step_e                   step_o,
  output logic signed [ACC_W-1:0] acc_d_o
);
  localparam logic signed [ACC_W:0] THR_P = (ACC_W+1)'(THRESH);
  localparam logic signed [ACC_W:0] THR_N = -THR_P;

  logic signed [ACC_W-1:0] acc_q, acc_d;
  logic signed [ACC_W:0]   delta, sum;
  step_e                   step;

  always_comb begin
    delta = '0;
    if (test_i) begin
      if (test_inc_i && !test_dec_i) delta = 1;
      else if (test_dec_i && !test_inc_i) delta = -1;
    end else if (!hold_i) begin
      // both flags high = invalid data, ramp forward
      if (early_i) delta = 1;
      else if (late_i) delta = -1;
    end
  end

  assign sum = (ACC_W+1)'(acc_q) + delta;

  always_comb begin
    step  = STEP_NONE;
    acc_d = sum[ACC_W-1:0];
    if (!test_i && !hold_i) begin
      if (sum >= THR_P) begin
        step  = STEP_FWD;
        acc_d = '0;
      end else if (sum <= THR_N) begin
        step  = STEP_BACK;
        acc_d = '0;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) acc_q <= '0;
    else         acc_q <= acc_d;
  end

  assign step_o  = step;
  assign acc_d_o = acc_d;
endmodule

// File: rtl/cdr_phase_sel.sv
module cdr_phase_sel
  import cdr_loop_pkg::*;
#(
  parameter int NUM_PHASES = 16,
  parameter int PH_W       = (NUM_PHASES > 1) ? $clog2(NUM_PHASES) : 1
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  step_e           step_i,
  output logic [PH_W-1:0] phase_o
);
  localparam logic [PH_W-1:0] LAST = PH_W'(NUM_PHASES - 1);

  logic [PH_W-1:0] phase_q, phase_d;

  always_comb begin
    phase_d = phase_q;
    unique case (step_i)
      STEP_FWD:  phase_d = (phase_q == LAST) ? '0 : phase_q + 1'b1;
      STEP_BACK: phase_d = (phase_q == '0) ? LAST : phase_q - 1'b1;
      default:   phase_d = phase_q;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) phase_q <= '0;
    else         phase_q <= phase_d;
  end

  assign phase_o = phase_q;
endmodule

// File: rtl/cdr_lock_det.sv
module cdr_lock_det #(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clear_i,
  input  logic [CNT_W-1:0] limit_i,
  output logic             locked_o
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W:0]   cnt_inc;
  logic             lock_q;

  assign cnt_inc = {1'b0, cnt_q} + 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      lock_q <= 1'b0;
    end else if (clear_i) begin
      cnt_q  <= '0;
      lock_q <= 1'b0;
    end else begin
      if (!(&cnt_q)) cnt_q <= cnt_inc[CNT_W-1:0];
      lock_q <= lock_q || (cnt_inc >= {1'b0, limit_i});
    end
  end

  assign locked_o = lock_q;
endmodule

// File: rtl/cdr_phase_loop.sv
module cdr_phase_loop
  import cdr_loop_pkg::*;
#(
  parameter int NUM_PHASES = 16,
  parameter int ACC_W      = 8,
  parameter int THRESH     = 8,
  parameter int LOCK_W     = 8,
  parameter int DATA_W     = 10,
  parameter int PH_W       = (NUM_PHASES > 1) ? $clog2(NUM_PHASES) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              track_en_i,
  input  logic              test_mode_i,
  input  logic              test_inc_i,
  input  logic              test_dec_i,
  input  logic              early_i,
  input  logic              late_i,
  input  logic [LOCK_W-1:0] lock_limit_i,
  input  logic [DATA_W-1:0] rx_data_i,
  output logic [DATA_W-1:0] rx_data_o,
  output logic [PH_W-1:0]   phase_idx_o,
  output logic              locked_o
);
  logic                    hold;
  step_e                   step;
  logic signed [ACC_W-1:0] acc_d;
  logic [DATA_W-1:0]       acc_view, data_q;

  assign hold = !track_en_i && !test_mode_i;

  cdr_loop_filter #(.ACC_W(ACC_W), .THRESH(THRESH)) u_filter (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .hold_i     (hold),
    .test_i     (test_mode_i),
    .early_i    (early_i),
    .late_i     (late_i),
    .test_inc_i (test_inc_i),
    .test_dec_i (test_dec_i),
    .step_o     (step),
    .acc_d_o    (acc_d)
  );

  cdr_phase_sel #(.NUM_PHASES(NUM_PHASES), .PH_W(PH_W)) u_phase (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .step_i  (step),
    .phase_o (phase_idx_o)
  );

  cdr_lock_det #(.CNT_W(LOCK_W)) u_lock (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clear_i  ((step != STEP_NONE) || !track_en_i || test_mode_i),
    .limit_i  (lock_limit_i),
    .locked_o (locked_o)
  );

  generate
    if (DATA_W > ACC_W) begin : g_sext
      assign acc_view = {{(DATA_W-ACC_W){acc_d[ACC_W-1]}}, acc_d};
    end else begin : g_trunc
      assign acc_view = acc_d[DATA_W-1:0];
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          data_q <= '0;
    else if (test_mode_i) data_q <= acc_view;
    else if (track_en_i)  data_q <= rx_data_i;
  end

  assign rx_data_o = data_q;
endmodule

// File: rtl/cdr_phase_loop_chk.sv
module cdr_phase_loop_chk #(
  parameter int NUM_PHASES = 16,
  parameter int DATA_W     = 10,
  parameter int PH_W       = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              track_en_i,
  input logic              test_mode_i,
  input logic [DATA_W-1:0] rx_data_i,
  input logic [DATA_W-1:0] rx_data_o,
  input logic [PH_W-1:0]   phase_idx_o,
  input logic              locked_o
);
  function automatic logic [PH_W-1:0] nxt(input logic [PH_W-1:0] p);
    return (p == PH_W'(NUM_PHASES-1)) ? '0 : p + 1'b1;
  endfunction
  function automatic logic [PH_W-1:0] prv(input logic [PH_W-1:0] p);
    return (p == '0) ? PH_W'(NUM_PHASES-1) : p - 1'b1;
  endfunction

  // R5
  single_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_idx_o != $past(phase_idx_o)) |->
      (phase_idx_o == nxt($past(phase_idx_o)) || phase_idx_o == prv($past(phase_idx_o))));

  // R7
  hold_freeze_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!track_en_i && !test_mode_i) |=> ($stable(phase_idx_o) && $stable(rx_data_o) && !locked_o));

  // R8
  test_no_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    test_mode_i |=> $stable(phase_idx_o));

  // R9
  step_unlock_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_idx_o != $past(phase_idx_o)) |-> !locked_o);

  // R10
  data_pass_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (track_en_i && !test_mode_i) |=> (rx_data_o == $past(rx_data_i)));
endmodule

bind cdr_phase_loop cdr_phase_loop_chk #(
  .NUM_PHASES (NUM_PHASES),
  .DATA_W     (DATA_W),
  .PH_W       (PH_W)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .track_en_i  (track_en_i),
  .test_mode_i (test_mode_i),
  .rx_data_i   (rx_data_i),
  .rx_data_o   (rx_data_o),
  .phase_idx_o (phase_idx_o),
  .locked_o    (locked_o)
);

// File: tb/cdr_phase_loop_tb.sv
module cdr_phase_loop_tb;
  localparam int NP = 16, THR = 8, LW = 8, DW = 10, PW = 4;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic track_en, test_mode, test_inc, test_dec, early, late;
  logic [LW-1:0] lock_limit;
  logic [DW-1:0] rx_data_i, rx_data_o;
  logic [PW-1:0] phase;
  logic locked;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  cdr_phase_loop u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .track_en_i(track_en), .test_mode_i(test_mode),
    .test_inc_i(test_inc), .test_dec_i(test_dec), .early_i(early), .late_i(late),
    .lock_limit_i(lock_limit), .rx_data_i(rx_data_i), .rx_data_o(rx_data_o),
    .phase_idx_o(phase), .locked_o(locked)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic tick(input int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_ni = 1'b0;
    track_en = 1; test_mode = 0; test_inc = 0; test_dec = 0;
    early = 0; late = 0; lock_limit = 5; rx_data_i = '0;
    tick(2);
    rst_ni = 1'b1;
  endtask

  task automatic t_reset();
    @(negedge clk);
    rst_ni = 1'b0; rx_data_i = 10'h3FF; early = 1;
    tick(2);
    check("R1 phase", phase, 0);
    check("R1 locked", locked, 0);
    check("R1 data", rx_data_o, 0);
    early = 0; rx_data_i = '0; test_mode = 1;
    rst_ni = 1'b1;
    tick(1);
    check("R1 acc zero", rx_data_o, 0);
  endtask

  task automatic t_early();
    do_reset();
    early = 1;
    tick(THR - 1);
    check("R2 before threshold", phase, 0);
    tick(1);
    check("R2 advance", phase, 1);
    tick(THR - 1);
    check("R2 acc cleared", phase, 1);
    tick(1);
    check("R2 second advance", phase, 2);
    early = 0;
  endtask

  task automatic t_late_wrap();
    do_reset();
    late = 1;
    tick(THR - 1);
    check("R3 before threshold", phase, 0);
    tick(1);
    check("R5 wrap down", phase, NP - 1);
    late = 0; early = 1;
    tick(THR);
    check("R5 wrap up", phase, 0);
    early = 0;
  endtask

  task automatic t_jitter();
    do_reset();
    for (int i = 0; i < 40; i++) begin
      early = (i % 2) == 0;
      late  = (i % 2) == 1;
      tick(1);
    end
    check("R4 alternating", phase, 0);
    early = 0; late = 0;
  endtask

  task automatic t_invalid();
    do_reset();
    early = 1; late = 1;
    tick(3 * THR);
    check("R6 ramp", phase, 3);
    early = 0; late = 0;
  endtask

  task automatic t_hold();
    do_reset();
    rx_data_i = 10'h155; early = 1;
    tick(THR - 1);
    check("R10 pass", rx_data_o, 10'h155);
    track_en = 0; rx_data_i = 10'h2AA;
    tick(5);
    check("R7 data frozen", rx_data_o, 10'h155);
    check("R7 phase frozen", phase, 0);
    check("R7 unlocked", locked, 0);
    track_en = 1;
    tick(1);
    check("R7 acc kept", phase, 1);
    check("R10 resume", rx_data_o, 10'h2AA);
    early = 0;
  endtask

  task automatic t_test();
    do_reset();
    test_mode = 1; test_inc = 1;
    tick(3);
    check("R8 inc", rx_data_o, 3);
    test_inc = 0; test_dec = 1;
    tick(5);
    check("R8 dec sext", rx_data_o, 10'h3FE);
    test_inc = 1;
    tick(2);
    check("R8 both", rx_data_o, 10'h3FE);
    test_dec = 0;
    tick(20);
    check("R8 no step", phase, 0);
    check("R8 value", rx_data_o, 18);
    test_inc = 0; test_mode = 0;
  endtask

  task automatic t_lock();
    do_reset();
    tick(4);
    check("R9 not yet", locked, 0);
    tick(1);
    check("R9 locked", locked, 1);
    early = 1;
    tick(THR - 1);
    check("R9 kept", locked, 1);
    tick(1);
    check("R9 dropped on step", locked, 0);
    early = 0;
    tick(5);
    check("R9 relock", locked, 1);
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    track_en = 1; test_mode = 0; test_inc = 0; test_dec = 0;
    early = 0; late = 0; lock_limit = 5; rx_data_i = '0;
    t_reset();
    t_early();
    t_late_wrap();
    t_jitter();
    t_invalid();
    t_hold();
    t_test();
    t_lock();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule